// File: doc/BRIEF.md
# Hyperbolic CORDIC Exponential Unit

This block evaluates hyperbolic functions of one signed fixed-point argument. It uses shift-and-add micro-rotations in hyperbolic rotation mode. A one-cycle `start` pulse captures the argument. The unit then performs one micro-rotation per clock. Each step rotates by plus or minus atanh(2^-i), with the sign taken from the residual angle. Once the schedule is complete, the unit registers four results: cosh(z), sinh(z), exp(z) formed as their sum, and exp(-z) formed as their difference.

The shift index starts at 1, because atanh(1) is unbounded. Some indices run twice in a row so that the rotations converge: index 4, then index 13, and so on, where each repeat point is three times the previous one plus one. The x register does not start at 1. It is loaded with the reciprocal of the hyperbolic gain of the whole schedule, so the outputs need no gain correction. An argument beyond the convergence limit is still processed, but it raises a range flag together with `done`.

A three-state controller sequences the work:
- **IDLE** goes to **ROTATE** when `start` is high. This is the transition that loads the datapath.
- **ROTATE** stays in ROTATE until the last scheduled step, then goes to **FINISH**.
- **FINISH** goes back to **IDLE** after one cycle, in which the results are registered and `done` is raised.

Top module: `hyp_cordic_exp`

## Requirements
- R1: All data is 32-bit two's complement with 16 fraction bits, so 1.0 is 65536. For a raw argument in the range −73276..73276, the outputs `cosh_q`, `sinh_q`, `exp_pos_q` and `exp_neg_q` each lie within 328 LSB (0.005) of cosh(z), sinh(z), e^z and e^−z. Negative arguments are included.
- R2: At every completion, `exp_pos_q` equals `cosh_q + sinh_q` exactly and `exp_neg_q` equals `cosh_q − sinh_q` exactly.
- R3: A `start` sampled high at a rising edge while idle is accepted. `done` is then high for exactly one cycle, beginning at the 17th rising edge after the accepting edge.
- R4: `busy` rises at the accepting edge, stays high through the whole computation, and falls at the edge where `done` rises.
- R5: A `start` pulse while `busy` is high is ignored. No extra `done` follows, and the results belong to the accepted argument.
- R6: Between completions, the four results and `range_err` hold their values, whatever `arg_z` and `start` do.
- R7: `range_err` is updated with each `done`. It is 1 exactly when the captured raw argument is greater than 73276 or less than −73276.
- R8: An active-low `rst_n` clears `busy`, `done`, `range_err` and all four results to zero.
- R9: The schedule has 16 micro-rotations with shift indices 1, 2, 3, 4, 4, 5, …, 13, 13, 14. At z = 0 the matching gain pre-scale gives `cosh_q` within 32 LSB of 65536 and `sinh_q` within 32 LSB of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Accept `arg_z` and begin a computation when idle |
| arg_z | input | 32 | Signed argument, 16 fraction bits |
| cosh_q | output | 32 | Registered cosh(z) |
| sinh_q | output | 32 | Registered sinh(z) |
| exp_pos_q | output | 32 | Registered e^z (cosh + sinh) |
| exp_neg_q | output | 32 | Registered e^−z (cosh − sinh) |
| busy | output | 1 | Computation in progress |
| done | output | 1 | One-cycle completion strobe |
| range_err | output | 1 | Captured argument exceeded the convergence limit |

## Verification
The hardest thing to observe from the ports is whether the repeated indices and the matching gain constant are right. Near z = 1, a missing repeat still leaves the results inside the 0.005 accuracy band. The stimulus therefore includes z = 0, where the expected outputs are exactly 1 and 0 and a tight 32-LSB band exposes a gain error of about 100 LSB. The bench also injects a second `start` several cycles into a busy computation, and it drops reset in mid-computation, so that the ignore rule and the clearing rule are both exercised against results that are not zero.

// File: rtl/hypcx_pkg.sv
package hypcx_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ROTATE = 2'd1,
        ST_FINISH = 2'd2
    } hyp_state_t;

    // Power series for inverse hyperbolic tangent, valid for |t| <= 0.5
    function automatic real atanh_series(input real t);
        real acc;
        real pw;
        acc = 0.0;
        pw  = t;
        for (int k = 0; k < 30; k++) begin
            acc = acc + pw / real'(2 * k + 1);
            pw  = pw * t * t;
        end
        return acc;
    endfunction

    // Shift index used at a given step of the schedule (repeats at 4, 13, 40, ...)
    function automatic int sched_shift(input int step);
        int  idx;
        int  rep_at;
        bit  taken;
        idx    = 1;
        rep_at = 4;
        taken  = 1'b0;
        for (int s = 0; s < step; s++) begin
            if (idx == rep_at && !taken) begin
                taken = 1'b1;
            end else begin
                if (idx == rep_at) begin
                    rep_at = 3 * rep_at + 1;
                    taken  = 1'b0;
                end
                idx = idx + 1;
            end
        end
        return idx;
    endfunction

    // Rounded fixed-point value of atanh(2^-i)
    function automatic int angle_q(input int i, input int frac);
        real a;
        a = atanh_series(2.0 ** (-i));
        return $rtoi(a * (2.0 ** frac) + 0.5);
    endfunction

    // Rounded fixed-point reciprocal of the schedule's hyperbolic gain
    function automatic int inv_gain_q(input int nsteps, input int frac);
        real k;
        int  i;
        k = 1.0;
        for (int s = 0; s < nsteps; s++) begin
            i = sched_shift(s);
            k = k * $sqrt(1.0 - 2.0 ** (-2 * i));
        end
        return $rtoi((2.0 ** frac) / k + 0.5);
    endfunction

endpackage

// File: rtl/hypcx_angle_rom.sv
module hypcx_angle_rom
    import hypcx_pkg::*;
#(
    parameter int W       = 32,
    parameter int FRAC    = 16,
    parameter int MAX_IDX = 14,
    parameter int IDX_W   = 4
) (
    input  logic [IDX_W-1:0] idx_i,
    output logic [W-1:0]     angle_o
);

    localparam int DEPTH = 2 ** IDX_W;

    logic [W-1:0] tbl [DEPTH];

    // Table entries are computed at elaboration; index 0 and unused slots are zero
    for (genvar g = 0; g < DEPTH; g++) begin : g_ang
        if (g == 0 || g > MAX_IDX) begin : g_zero
            assign tbl[g] = '0;
        end else begin : g_val
            assign tbl[g] = W'(angle_q(g, FRAC));
        end
    end

    assign angle_o = tbl[idx_i];

endmodule

// File: rtl/hypcx_sched.sv
module hypcx_sched #(
    parameter int N_STEPS = 16,
    parameter int MAX_IDX = 14,
    parameter int IDX_W   = 4,
    parameter int CNT_W   = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             begin_i,
    input  logic             advance_i,
    output logic [IDX_W-1:0] idx_o,
    output logic             last_o
);

    localparam int RP_W = IDX_W + 2;

    logic [CNT_W-1:0] step_q;
    logic [IDX_W-1:0] idx_q;
    logic [RP_W-1:0]  rep_at_q;
    logic             rep_taken_q;
    logic             at_rep;

    assign at_rep = (RP_W'(idx_q) == rep_at_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            step_q      <= '0;
            idx_q       <= IDX_W'(1);
            rep_at_q    <= RP_W'(4);
            rep_taken_q <= 1'b0;
        end else if (begin_i) begin
            step_q      <= '0;
            idx_q       <= IDX_W'(1);
            rep_at_q    <= RP_W'(4);
            rep_taken_q <= 1'b0;
        end else if (advance_i) begin
            step_q <= step_q + 1'b1;
            if (at_rep && !rep_taken_q) begin
                rep_taken_q <= 1'b1;
            end else begin
                if (at_rep) begin
                    rep_at_q    <= RP_W'(3 * rep_at_q + 1);
                    rep_taken_q <= 1'b0;
                end
                idx_q <= idx_q + 1'b1;
            end
        end
    end

    assign idx_o  = idx_q;
    assign last_o = (step_q == CNT_W'(N_STEPS - 1));

    // R9: the index used by a micro-rotation is always a legal table index
    a_r9_idx_range: assert property (@(posedge clk) disable iff (!rst_n)
        advance_i |-> (idx_o >= IDX_W'(1)) && (idx_o <= IDX_W'(MAX_IDX)));

    // R9: from one micro-rotation to the next, the index either repeats or steps by one
    a_r9_idx_step: assert property (@(posedge clk) disable iff (!rst_n)
        (advance_i && !last_o) |=> (idx_o == $past(idx_o)) || (idx_o == $past(idx_o) + 1'b1));

endmodule

// File: rtl/hypcx_datapath.sv
module hypcx_datapath #(
    parameter int W     = 32,
    parameter int IDX_W = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load_i,
    input  logic signed [W-1:0] x_init_i,
    input  logic signed [W-1:0] z_init_i,
    input  logic                step_i,
    input  logic [IDX_W-1:0]    shift_i,
    input  logic signed [W-1:0] angle_i,
    output logic signed [W-1:0] x_o,
    output logic signed [W-1:0] y_o
);

    logic signed [W-1:0] x_q, y_q, z_q;
    logic signed [W-1:0] x_sh, y_sh;
    logic signed [W-1:0] x_nx, y_nx, z_nx;
    logic                go_down;

    // Both shifted terms come from the previous-step values
    assign x_sh    = x_q >>> shift_i;
    assign y_sh    = y_q >>> shift_i;
    assign go_down = z_q[W-1];

    always_comb begin
        if (go_down) begin
            x_nx = x_q - y_sh;
            y_nx = y_q - x_sh;
            z_nx = z_q + angle_i;
        end else begin
            x_nx = x_q + y_sh;
            y_nx = y_q + x_sh;
            z_nx = z_q - angle_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            x_q <= '0;
            y_q <= '0;
            z_q <= '0;
        end else if (load_i) begin
            x_q <= x_init_i;
            y_q <= '0;
            z_q <= z_init_i;
        end else if (step_i) begin
            x_q <= x_nx;
            y_q <= y_nx;
            z_q <= z_nx;
        end
    end

    assign x_o = x_q;
    assign y_o = y_q;

    // R1: the cosh accumulator never turns negative during rotation
    a_r1_x_positive: assert property (@(posedge clk) disable iff (!rst_n)
        step_i |=> !x_o[W-1]);

endmodule

// File: rtl/hyp_cordic_exp.sv
module hyp_cordic_exp
    import hypcx_pkg::*;
#(
    parameter int W       = 32,
    parameter int FRAC    = 16,
    parameter int N_STEPS = 16,
    parameter int Z_LIM_Q = 73276
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] arg_z,
    output logic [W-1:0] cosh_q,
    output logic [W-1:0] sinh_q,
    output logic [W-1:0] exp_pos_q,
    output logic [W-1:0] exp_neg_q,
    output logic         busy,
    output logic         done,
    output logic         range_err
);

    localparam int MAX_IDX = sched_shift(N_STEPS - 1);
    localparam int IDX_W   = $clog2(MAX_IDX + 1);
    localparam int CNT_W   = (N_STEPS > 1) ? $clog2(N_STEPS) : 1;
    localparam logic signed [W-1:0] X_INIT = W'(inv_gain_q(N_STEPS, FRAC));
    localparam logic signed [W-1:0] ZL_POS = W'(Z_LIM_Q);
    localparam logic signed [W-1:0] ZL_NEG = -ZL_POS;

    hyp_state_t state_q, state_d;

    logic                accept;
    logic                rotating;
    logic                last_step;
    logic [IDX_W-1:0]    shift_idx;
    logic [W-1:0]        angle;
    logic signed [W-1:0] x_cur, y_cur;
    logic                out_of_range;
    logic                rng_pend_q;

    assign accept       = (state_q == ST_IDLE) && start;
    assign rotating     = (state_q == ST_ROTATE);
    assign out_of_range = ($signed(arg_z) > ZL_POS) || ($signed(arg_z) < ZL_NEG);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start)     state_d = ST_ROTATE;
            ST_ROTATE: if (last_step) state_d = ST_FINISH;
            ST_FINISH:                state_d = ST_IDLE;
            default:                  state_d = ST_IDLE;
        endcase
    end

    // Output process: handshake, range flag and result registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy       <= 1'b0;
            done       <= 1'b0;
            range_err  <= 1'b0;
            rng_pend_q <= 1'b0;
            cosh_q     <= '0;
            sinh_q     <= '0;
            exp_pos_q  <= '0;
            exp_neg_q  <= '0;
        end else begin
            done <= 1'b0;
            if (accept) begin
                busy       <= 1'b1;
                rng_pend_q <= out_of_range;
            end
            if (state_q == ST_FINISH) begin
                busy      <= 1'b0;
                done      <= 1'b1;
                range_err <= rng_pend_q;
                cosh_q    <= x_cur;
                sinh_q    <= y_cur;
                exp_pos_q <= x_cur + y_cur;
                exp_neg_q <= x_cur - y_cur;
            end
        end
    end

    hypcx_sched #(
        .N_STEPS (N_STEPS),
        .MAX_IDX (MAX_IDX),
        .IDX_W   (IDX_W),
        .CNT_W   (CNT_W)
    ) u_sched (
        .clk       (clk),
        .rst_n     (rst_n),
        .begin_i   (accept),
        .advance_i (rotating),
        .idx_o     (shift_idx),
        .last_o    (last_step)
    );

    hypcx_angle_rom #(
        .W       (W),
        .FRAC    (FRAC),
        .MAX_IDX (MAX_IDX),
        .IDX_W   (IDX_W)
    ) u_rom (
        .idx_i   (shift_idx),
        .angle_o (angle)
    );

    hypcx_datapath #(
        .W     (W),
        .IDX_W (IDX_W)
    ) u_dp (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (accept),
        .x_init_i (X_INIT),
        .z_init_i ($signed(arg_z)),
        .step_i   (rotating),
        .shift_i  (shift_idx),
        .angle_i  ($signed(angle)),
        .x_o      (x_cur),
        .y_o      (y_cur)
    );

    // R3: completion strobe lasts a single cycle
    a_r3_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R4: busy is already low when done is presented
    a_r4_busy_low_at_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R4: done is only ever preceded by a busy cycle
    a_r4_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(busy));

    // R5: busy can only rise because start was sampled
    a_r5_rise_needs_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));

    // R6: results hold between completions
    a_r6_hold_results: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(cosh_q) && $stable(sinh_q) && $stable(exp_pos_q) && $stable(exp_neg_q));

    // R7: the range flag only rises together with done
    a_r7_flag_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(range_err) |-> done);

endmodule

// File: tb/sim_hyp_cordic_exp.sv
module sim_hyp_cordic_exp;

    localparam int CLK_PERIOD = 10;
    localparam longint ONE    = 65536;
    localparam longint TOL    = 328;
    localparam longint TOL0   = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] arg_z = '0;
    logic [31:0] cosh_q, sinh_q, exp_pos_q, exp_neg_q;
    logic        busy, done, range_err;

    int n_chk  = 0;
    int n_fail = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    hyp_cordic_exp u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .arg_z     (arg_z),
        .cosh_q    (cosh_q),
        .sinh_q    (sinh_q),
        .exp_pos_q (exp_pos_q),
        .exp_neg_q (exp_neg_q),
        .busy      (busy),
        .done      (done),
        .range_err (range_err)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic longint sv(input logic [31:0] v);
        return longint'($signed(v));
    endfunction

    function automatic longint to_q(input real v);
        return longint'($rtoi(v * 65536.0));
    endfunction

    function automatic longint absd(input longint a, input longint b);
        return (a > b) ? a - b : b - a;
    endfunction

    // Issue one computation; optionally inject a second start while busy
    task automatic run_op(input logic [31:0] z, input int inject_at, input logic [31:0] z2,
                          output int lat, output bit busy_ok);
        @(negedge clk);
        arg_z = z;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat     = 0;
        busy_ok = busy;
        while (!done && lat < 60) begin
            @(negedge clk);
            lat++;
            if (lat == inject_at) begin
                arg_z = z2;
                start = 1'b1;
            end else begin
                start = 1'b0;
            end
            if (!done && !busy) busy_ok = 1'b0;
        end
        start = 1'b0;
    endtask

    task automatic t_reset_state();
        chk(busy == 1'b0, "R8", "busy after reset", longint'(busy), 0);
        chk(done == 1'b0, "R8", "done after reset", longint'(done), 0);
        chk(range_err == 1'b0, "R8", "range_err after reset", longint'(range_err), 0);
        chk(cosh_q == '0 && sinh_q == '0 && exp_pos_q == '0 && exp_neg_q == '0,
            "R8", "results after reset", sv(cosh_q), 0);
    endtask

    task automatic t_accuracy(input longint zq);
        int     lat;
        bit     bok;
        real    zr;
        longint ec, es;
        run_op(32'(zq), -1, '0, lat, bok);
        zr = real'(zq) / 65536.0;
        ec = to_q(($exp(zr) + $exp(-zr)) / 2.0);
        es = to_q(($exp(zr) - $exp(-zr)) / 2.0);
        chk(lat == 17, "R3", "latency", lat, 17);
        chk(bok && !busy, "R4", "busy span", longint'(busy), 0);
        chk(absd(sv(cosh_q), ec) <= TOL, "R1", "cosh", sv(cosh_q), ec);
        chk(absd(sv(sinh_q), es) <= TOL, "R1", "sinh", sv(sinh_q), es);
        chk(absd(sv(exp_pos_q), to_q($exp(zr))) <= TOL, "R1", "exp(z)", sv(exp_pos_q), to_q($exp(zr)));
        chk(absd(sv(exp_neg_q), to_q($exp(-zr))) <= TOL, "R1", "exp(-z)", sv(exp_neg_q), to_q($exp(-zr)));
        chk(exp_pos_q == cosh_q + sinh_q, "R2", "sum", sv(exp_pos_q), sv(cosh_q + sinh_q));
        chk(exp_neg_q == cosh_q - sinh_q, "R2", "difference", sv(exp_neg_q), sv(cosh_q - sinh_q));
        chk(range_err == 1'b0, "R7", "in-range flag", longint'(range_err), 0);
        @(negedge clk);
        chk(done == 1'b0, "R3", "done width", longint'(done), 0);
    endtask

    task automatic t_zero_gain();
        int lat;
        bit bok;
        run_op('0, -1, '0, lat, bok);
        chk(absd(sv(cosh_q), ONE) <= TOL0, "R9", "cosh(0)", sv(cosh_q), ONE);
        chk(absd(sv(sinh_q), 0) <= TOL0, "R9", "sinh(0)", sv(sinh_q), 0);
    endtask

    task automatic t_range(input longint zq, input bit exp_flag);
        int lat;
        bit bok;
        run_op(32'(zq), -1, '0, lat, bok);
        chk(done == 1'b1 && range_err == exp_flag, "R7", "range flag",
            longint'(range_err), longint'(exp_flag));
    endtask

    task automatic t_start_while_busy();
        int     lat;
        bit     bok;
        bit     extra;
        longint ec;
        run_op(32'(ONE / 2), 5, 32'(-ONE), lat, bok);
        ec = to_q(($exp(0.5) + $exp(-0.5)) / 2.0);
        chk(lat == 17, "R5", "latency with ignored start", lat, 17);
        chk(absd(sv(cosh_q), ec) <= TOL, "R5", "cosh of accepted arg", sv(cosh_q), ec);
        chk(sv(sinh_q) > 0, "R5", "sinh sign of accepted arg", sv(sinh_q), 1);
        extra = 1'b0;
        for (int k = 0; k < 25; k++) begin
            @(negedge clk);
            if (done) extra = 1'b1;
        end
        chk(!extra, "R5", "no second done", longint'(extra), 0);
    endtask

    task automatic t_hold();
        logic [31:0] c0, s0, p0, n0;
        logic        r0;
        int          lat;
        bit          bok;
        bit          same;
        run_op(32'(ONE), -1, '0, lat, bok);
        c0 = cosh_q; s0 = sinh_q; p0 = exp_pos_q; n0 = exp_neg_q; r0 = range_err;
        arg_z = 32'h7fff_0000;
        same  = 1'b1;
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            if (cosh_q != c0 || sinh_q != s0 || exp_pos_q != p0 || exp_neg_q != n0 || range_err != r0)
                same = 1'b0;
        end
        chk(same, "R6", "hold while idle", sv(cosh_q), sv(c0));
        @(negedge clk);
        arg_z = 32'(-ONE / 4);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (8) @(negedge clk);
        chk(cosh_q == c0 && sinh_q == s0, "R6", "hold during next op", sv(sinh_q), sv(s0));
        while (!done) @(negedge clk);
    endtask

    task automatic t_reset_mid();
        @(negedge clk);
        arg_z = 32'(ONE);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (5) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk(!busy && !done && !range_err, "R8", "control after mid reset", longint'(busy), 0);
        chk(cosh_q == '0 && sinh_q == '0 && exp_pos_q == '0 && exp_neg_q == '0,
            "R8", "results after mid reset", sv(cosh_q), 0);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset_state();
        rst_n = 1'b1;
        @(negedge clk);
        t_accuracy(ONE);
        t_accuracy(-ONE);
        t_accuracy(ONE / 2);
        t_accuracy(-(3 * ONE) / 4);
        t_accuracy(73276);
        t_accuracy(-73276);
        t_zero_gain();
        t_range(73277, 1'b1);
        t_range(-73277, 1'b1);
        t_range(1000, 1'b0);
        t_start_while_busy();
        t_hold();
        t_reset_mid();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule